// File: doc/BRIEF.md
# Management Bus Frame Monitor

A passive observer for the two-wire serial management bus found between Ethernet MACs and PHYs. It runs from a system clock much faster than the management clock. Both bus lines pass through synchronizers. The data line is sampled on every rising edge of the management clock, and each sampled bit advances a frame parser. The parser covers the optional preamble, the start pattern, the opcode, the PHY address, the register address, the turnaround and the data word.

When a frame completes cleanly, the monitor raises a one-cycle `frame_valid_o` pulse. With that pulse it presents the direction, both addresses and the 16-bit data word. A malformed frame raises a one-cycle `error_valid_o` pulse with a cause code. After an error, bits are discarded until 64 clock edges have passed since the frame's first bit. The discard also ends early if the management clock stalls for more than 1.5 average bit periods. The block never drives the bus.

Top module: `mgmt_frame_monitor`

## Requirements
- R1: The data line is taken only at rising edges of the management clock. Data changes while the clock is high, and the values present at falling edges, have no effect on the decoded frame.
- R2: A frame consists of 32 one-bits, start 0 then 1, two opcode bits, 5 PHY address bits (MSB first), 5 register address bits (MSB first), two turnaround bits and 16 data bits (MSB first). It produces one `frame_valid_o` pulse. `frame_read_o` is 1 for opcode bits 1 then 0 (read) and 0 for 0 then 1 (write).
- R3: A frame whose very first bit is 0 has no preamble. That bit is taken as the first start bit, and the rest of the frame decodes as in R2.
- R4: A 0 bit inside the preamble, after its first bit, gives an error pulse with `error_cause_o` = 1.
- R5: A start field other than 0 then 1 gives an error pulse with cause 2.
- R6: Two equal opcode bits give an error pulse with cause 3.
- R7: A second turnaround bit of 1 gives cause 4. A first turnaround bit of 0 gives cause 4 on a write. On a read the first turnaround bit is not checked.
- R8: After an error with cause 1 to 4, all bits are ignored until the 64th rising edge counted from the frame's first bit. During that time there are no pulses, even if the ignored bits form a valid frame. The bit after the 64th edge starts a new frame.
- R9: During the post-error discard, a gap since the last rising edge longer than 1.5 times the average bit period gives an error pulse with cause 5 and an immediate return to idle. The average is the span from the frame's first edge to its last edge, divided by the number of intervals. Clock stalls outside the discard produce nothing.
- R10: `frame_valid_o` and `error_valid_o` are each one system clock wide and never high together. The frame fields hold their values between `frame_valid_o` pulses.
- R11: After reset both pulses are low and all fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_clk_i | input | 1 | Management bus clock (asynchronous) |
| mgmt_data_i | input | 1 | Management bus data (asynchronous) |
| frame_valid_o | output | 1 | One-cycle pulse when a good frame completes |
| frame_read_o | output | 1 | 1 = read frame, 0 = write frame |
| frame_phy_o | output | 5 | PHY address of the last good frame |
| frame_reg_o | output | 5 | Register address of the last good frame |
| frame_data_o | output | 16 | Data word of the last good frame |
| error_valid_o | output | 1 | One-cycle pulse on a framing error or stall |
| error_cause_o | output | 3 | 1 preamble, 2 start, 3 opcode, 4 turnaround, 5 stall |

## Verification
Suppose the parser's state or its edge count goes wrong. The effect shows at the ports no later than the end of the frame in progress. A good frame then either gives no `frame_valid_o` or carries shifted addresses or data, or an error pulse appears at an edge where none is due. Suppose instead the discard count or the stall average goes wrong. The monitor then misses the good frame that follows an error, or it emits or withholds the cause-5 pulse. The directed tests observe each of these outcomes within one frame of the stimulus.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  typedef enum logic [3:0] {
    ST_PRE, ST_SFD0, ST_SFD1, ST_OP0, ST_OP1,
    ST_PHY, ST_REG, ST_TA0, ST_TA1, ST_DATA, ST_SKIP
  } mfm_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_PRE   = 3'd1,
    CAUSE_SFD   = 3'd2,
    CAUSE_OP    = 3'd3,
    CAUSE_TA    = 3'd4,
    CAUSE_STALL = 3'd5
  } mfm_cause_e;
endpackage

// File: rtl/mfm_sync.sv
module mfm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mgmt_clk_i,
  input  logic mgmt_data_i,
  output logic rise_o,
  output logic bit_o
);
  logic [STAGES-1:0] clk_sh_q, dat_sh_q;
  logic              clk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sh_q   <= '0;
      dat_sh_q   <= '0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_sh_q   <= {clk_sh_q[STAGES-2:0], mgmt_clk_i};
      dat_sh_q   <= {dat_sh_q[STAGES-2:0], mgmt_data_i};
      clk_prev_q <= clk_sh_q[STAGES-1];
    end
  end

  assign rise_o = clk_sh_q[STAGES-1] & ~clk_prev_q;
  assign bit_o  = dat_sh_q[STAGES-1];
endmodule

// File: rtl/mfm_stall.sv
module mfm_stall #(
  parameter int CNT_W = 20,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             en_i,
  input  logic [IDX_W-1:0] bit_cnt_i,
  output logic             stall_o
);
  localparam int PW = CNT_W + IDX_W + 2;

  logic [CNT_W-1:0] gap_q, span_q;
  logic [CNT_W:0]   span_sum;
  logic [IDX_W-1:0] nint;
  logic [PW-1:0]    lhs, rhs;

  // gap_q: system clocks since last edge, minus one; span_q: first edge to last edge
  assign span_sum = {1'b0, span_q} + {1'b0, gap_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      span_q <= '0;
    end else if (rise_i) begin
      gap_q <= '0;
      if (bit_cnt_i == '0)      span_q <= '0;
      else if (span_sum[CNT_W]) span_q <= '1;
      else                      span_q <= span_sum[CNT_W-1:0];
    end else if (!(&gap_q)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // elapsed * 2 * intervals > 3 * span  <=>  elapsed > 1.5 * average period
  assign nint = bit_cnt_i - 1'b1;
  assign lhs  = PW'({1'b0, gap_q} + 1'b1) * PW'(nint) * PW'(2);
  assign rhs  = PW'(span_q) * PW'(3);

  assign stall_o = en_i && !rise_i && (bit_cnt_i > IDX_W'(1)) && (lhs > rhs);
endmodule

// File: rtl/mfm_frame.sv
module mfm_frame
  import mfm_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int SKIP_BITS = 64,
  parameter int IDX_W     = $clog2(SKIP_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              bit_i,
  input  logic              stall_i,
  output logic [IDX_W-1:0]  bit_cnt_o,
  output logic              skip_o,
  output logic              frame_valid_o,
  output logic              frame_read_o,
  output logic [ADDR_W-1:0] frame_phy_o,
  output logic [ADDR_W-1:0] frame_reg_o,
  output logic [DATA_W-1:0] frame_data_o,
  output logic              error_valid_o,
  output logic [2:0]        error_cause_o
);
  localparam int FLD_W = $clog2(DATA_W + 1);
  localparam logic [IDX_W-1:0] PRE_LAST  = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] SKIP_LAST = IDX_W'(SKIP_BITS - 1);
  localparam logic [FLD_W-1:0] ADDR_LAST = FLD_W'(ADDR_W - 1);
  localparam logic [FLD_W-1:0] DATA_LAST = FLD_W'(DATA_W - 1);

  mfm_state_e        state_q;
  logic [IDX_W-1:0]  bit_cnt_q;
  logic [FLD_W-1:0]  fld_q;
  logic              op0_q;
  logic [ADDR_W-1:0] phy_sh_q, reg_sh_q;
  logic [DATA_W-1:0] data_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_PRE;
      bit_cnt_q     <= '0;
      fld_q         <= '0;
      op0_q         <= 1'b0;
      phy_sh_q      <= '0;
      reg_sh_q      <= '0;
      data_sh_q     <= '0;
      frame_valid_o <= 1'b0;
      frame_read_o  <= 1'b0;
      frame_phy_o   <= '0;
      frame_reg_o   <= '0;
      frame_data_o  <= '0;
      error_valid_o <= 1'b0;
      error_cause_o <= CAUSE_NONE;
    end else begin
      frame_valid_o <= 1'b0;
      error_valid_o <= 1'b0;
      if (state_q == ST_SKIP && stall_i) begin
        state_q       <= ST_PRE;
        bit_cnt_q     <= '0;
        error_valid_o <= 1'b1;
        error_cause_o <= CAUSE_STALL;
      end else if (rise_i) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        unique case (state_q)
          ST_PRE: begin
            if (!bit_i && bit_cnt_q == '0) begin
              state_q <= ST_SFD1;           // no preamble: this is the first start bit
            end else if (!bit_i) begin
              state_q       <= ST_SKIP;
              error_valid_o <= 1'b1;
              error_cause_o <= CAUSE_PRE;
            end else if (bit_cnt_q == PRE_LAST) begin
              state_q <= ST_SFD0;
            end
          end
          ST_SFD0: begin
            if (bit_i) begin
              state_q       <= ST_SKIP;
              error_valid_o <= 1'b1;
              error_cause_o <= CAUSE_SFD;
            end else begin
              state_q <= ST_SFD1;
            end
          end
          ST_SFD1: begin
            if (!bit_i) begin
              state_q       <= ST_SKIP;
              error_valid_o <= 1'b1;
              error_cause_o <= CAUSE_SFD;
            end else begin
              state_q <= ST_OP0;
            end
          end
          ST_OP0: begin
            op0_q   <= bit_i;
            state_q <= ST_OP1;
          end
          ST_OP1: begin
            if (bit_i == op0_q) begin
              state_q       <= ST_SKIP;
              error_valid_o <= 1'b1;
              error_cause_o <= CAUSE_OP;
            end else begin
              state_q <= ST_PHY;
              fld_q   <= '0;
            end
          end
          ST_PHY: begin
            phy_sh_q <= {phy_sh_q[ADDR_W-2:0], bit_i};
            fld_q    <= fld_q + 1'b1;
            if (fld_q == ADDR_LAST) begin
              state_q <= ST_REG;
              fld_q   <= '0;
            end
          end
          ST_REG: begin
            reg_sh_q <= {reg_sh_q[ADDR_W-2:0], bit_i};
            fld_q    <= fld_q + 1'b1;
            if (fld_q == ADDR_LAST) state_q <= ST_TA0;
          end
          ST_TA0: begin
            // read: bus released by the master here, value not checked
            if (!op0_q && !bit_i) begin
              state_q       <= ST_SKIP;
              error_valid_o <= 1'b1;
              error_cause_o <= CAUSE_TA;
            end else begin
              state_q <= ST_TA1;
            end
          end
          ST_TA1: begin
            if (bit_i) begin
              state_q       <= ST_SKIP;
              error_valid_o <= 1'b1;
              error_cause_o <= CAUSE_TA;
            end else begin
              state_q <= ST_DATA;
              fld_q   <= '0;
            end
          end
          ST_DATA: begin
            data_sh_q <= {data_sh_q[DATA_W-2:0], bit_i};
            fld_q     <= fld_q + 1'b1;
            if (fld_q == DATA_LAST) begin
              state_q       <= ST_PRE;
              bit_cnt_q     <= '0;
              frame_valid_o <= 1'b1;
              frame_read_o  <= op0_q;
              frame_phy_o   <= phy_sh_q;
              frame_reg_o   <= reg_sh_q;
              frame_data_o  <= {data_sh_q[DATA_W-2:0], bit_i};
            end
          end
          ST_SKIP: begin
            if (bit_cnt_q == SKIP_LAST) begin
              state_q   <= ST_PRE;
              bit_cnt_q <= '0;
            end
          end
          default: begin
            state_q   <= ST_PRE;
            bit_cnt_q <= '0;
          end
        endcase
      end
    end
  end

  assign bit_cnt_o = bit_cnt_q;
  assign skip_o    = (state_q == ST_SKIP);
endmodule

// File: rtl/mgmt_frame_monitor.sv
module mgmt_frame_monitor #(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LEN     = 32,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int SKIP_BITS   = 64,
  parameter int CNT_W       = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mgmt_clk_i,
  input  logic              mgmt_data_i,
  output logic              frame_valid_o,
  output logic              frame_read_o,
  output logic [ADDR_W-1:0] frame_phy_o,
  output logic [ADDR_W-1:0] frame_reg_o,
  output logic [DATA_W-1:0] frame_data_o,
  output logic              error_valid_o,
  output logic [2:0]        error_cause_o
);
  localparam int IDX_W = $clog2(SKIP_BITS);

  logic             rise, bit_s, stall, in_skip;
  logic [IDX_W-1:0] bit_cnt;

  mfm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mgmt_clk_i  (mgmt_clk_i),
    .mgmt_data_i (mgmt_data_i),
    .rise_o      (rise),
    .bit_o       (bit_s)
  );

  mfm_stall #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_stall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .en_i      (in_skip),
    .bit_cnt_i (bit_cnt),
    .stall_o   (stall)
  );

  mfm_frame #(
    .PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SKIP_BITS(SKIP_BITS), .IDX_W(IDX_W)
  ) u_frame (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rise_i        (rise),
    .bit_i         (bit_s),
    .stall_i       (stall),
    .bit_cnt_o     (bit_cnt),
    .skip_o        (in_skip),
    .frame_valid_o (frame_valid_o),
    .frame_read_o  (frame_read_o),
    .frame_phy_o   (frame_phy_o),
    .frame_reg_o   (frame_reg_o),
    .frame_data_o  (frame_data_o),
    .error_valid_o (error_valid_o),
    .error_cause_o (error_cause_o)
  );
endmodule

// File: rtl/mfm_checker.sv
module mfm_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rise,
  input logic              in_skip,
  input logic              frame_valid_o,
  input logic              frame_read_o,
  input logic [ADDR_W-1:0] frame_phy_o,
  input logic [ADDR_W-1:0] frame_reg_o,
  input logic [DATA_W-1:0] frame_data_o,
  input logic              error_valid_o,
  input logic [2:0]        error_cause_o
);
  AST_FRAME_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $past(rise)); // R1
  AST_ERR_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_valid_o && error_cause_o != 3'd5) |-> $past(rise)); // R1
  AST_CAUSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_valid_o |-> (error_cause_o >= 3'd1 && error_cause_o <= 3'd5)); // R4
  AST_ERR_ENTERS_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_valid_o && error_cause_o != 3'd5) |-> in_skip); // R8
  AST_NO_FRAME_IN_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> !$past(in_skip)); // R8
  AST_STALL_FROM_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_valid_o && error_cause_o == 3'd5) |-> ($past(in_skip) && !$past(rise) && !in_skip)); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && error_valid_o)); // R10
  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_valid_o |=> !error_valid_o); // R10
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> $stable({frame_read_o, frame_phy_o, frame_reg_o, frame_data_o})); // R10
endmodule

bind mgmt_frame_monitor mfm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rise          (rise),
  .in_skip       (in_skip),
  .frame_valid_o (frame_valid_o),
  .frame_read_o  (frame_read_o),
  .frame_phy_o   (frame_phy_o),
  .frame_reg_o   (frame_reg_o),
  .frame_data_o  (frame_data_o),
  .error_valid_o (error_valid_o),
  .error_cause_o (error_cause_o)
);

// File: tb/sim_mgmt_frame_monitor.sv
`timescale 1ns/1ps
module sim_mgmt_frame_monitor;
  localparam int H = 4;  // system clocks per management clock phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc = 1'b0;
  logic md = 1'b1;
  logic fv, rd, ev;
  logic [4:0] phy, rg;
  logic [15:0] dat;
  logic [2:0] cause;

  int n_chk = 0, n_bad = 0;
  int fv_cnt = 0, ev_cnt = 0, wide_cnt = 0;
  logic fv_prev = 1'b0, ev_prev = 1'b0;
  logic [2:0] last_cause = 3'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mgmt_frame_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .mgmt_clk_i(mc), .mgmt_data_i(md),
    .frame_valid_o(fv), .frame_read_o(rd), .frame_phy_o(phy),
    .frame_reg_o(rg), .frame_data_o(dat),
    .error_valid_o(ev), .error_cause_o(cause)
  );

  always @(negedge clk) begin
    if (fv) fv_cnt++;
    if (ev) begin ev_cnt++; last_cause = cause; end
    if ((fv && fv_prev) || (ev && ev_prev) || (fv && ev)) wide_cnt++;
    fv_prev = fv;
    ev_prev = ev;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    @(negedge clk);
    md = b;
    repeat (H) @(negedge clk);
    mc = 1'b1;
    if (glitch) begin
      repeat (2) @(negedge clk);
      md = ~b;  // changes while high and at the falling edge
      repeat (H - 2) @(negedge clk);
    end else begin
      repeat (H) @(negedge clk);
    end
    mc = 1'b0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
  endtask

  task automatic send_field(input logic [15:0] v, input int w, input bit g);
    for (int i = w - 1; i >= 0; i--) send_bit(v[i], g);
  endtask

  task automatic send_frame(input bit pre, input logic [1:0] op, input logic [4:0] p,
                            input logic [4:0] r, input logic [1:0] ta,
                            input logic [15:0] d, input bit g);
    if (pre) send_ones(32);
    send_field(16'b01, 2, g);
    send_field({14'd0, op}, 2, g);
    send_field({11'd0, p}, 5, g);
    send_field({11'd0, r}, 5, g);
    send_field({14'd0, ta}, 2, g);
    send_field(d, 16, g);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic check_frame(input string req, input int f0, input logic r,
                             input logic [4:0] p, input logic [4:0] a, input logic [15:0] d);
    chk({req, " frame count"}, fv_cnt, f0 + 1);
    chk({req, " read flag"}, rd, r);
    chk({req, " phy addr"}, phy, p);
    chk({req, " reg addr"}, rg, a);
    chk({req, " data"}, dat, d);
  endtask

  task automatic t_reset();
    chk("R11 frame_valid", fv, 0);
    chk("R11 error_valid", ev, 0);
    chk("R11 fields", {rd, phy, rg, dat, cause}, 0);
  endtask

  task automatic t_write_pre();
    int f0 = fv_cnt;
    send_frame(1'b1, 2'b01, 5'h1B, 5'h04, 2'b10, 16'hA5C3, 1'b0);
    settle();
    check_frame("R2 write", f0, 1'b0, 5'h1B, 5'h04, 16'hA5C3);
  endtask

  task automatic t_read_pre();
    int f0 = fv_cnt;
    int e0 = ev_cnt;
    send_frame(1'b1, 2'b10, 5'h00, 5'h1F, 2'b00, 16'h0001, 1'b0);
    settle();
    check_frame("R7 read ta0 unchecked", f0, 1'b1, 5'h00, 5'h1F, 16'h0001);
    chk("R7 no error on read", ev_cnt, e0);
  endtask

  task automatic t_no_pre();
    int f0 = fv_cnt;
    send_frame(1'b0, 2'b01, 5'h15, 5'h0A, 2'b10, 16'hFFFF, 1'b0);
    settle();
    check_frame("R3 no preamble", f0, 1'b0, 5'h15, 5'h0A, 16'hFFFF);
  endtask

  task automatic t_glitch();
    int f0 = fv_cnt;
    send_frame(1'b1, 2'b10, 5'h0E, 5'h11, 2'b10, 16'h3C96, 1'b1);
    settle();
    check_frame("R1 rising only", f0, 1'b1, 5'h0E, 5'h11, 16'h3C96);
  endtask

  task automatic t_err(input string req, input int sent, input logic [2:0] exp_cause);
    int f0 = fv_cnt;
    int e0 = ev_cnt;
    send_ones(64 - sent);
    settle();
    chk({req, " one error pulse"}, ev_cnt, e0);
    chk({req, " cause"}, last_cause, exp_cause);
    chk({req, " no frame"}, fv_cnt, f0);
  endtask

  task automatic t_err_pre();
    int e0 = ev_cnt;
    send_ones(10);
    send_bit(1'b0, 1'b0);
    t_err("R4 preamble", 11, 3'd1);
    chk("R4 pulse count", ev_cnt, e0 + 1);
  endtask

  task automatic t_err_sfd();
    int e0 = ev_cnt;
    send_ones(33);
    t_err("R5 start", 33, 3'd2);
    chk("R5 pulse count", ev_cnt, e0 + 1);
  endtask

  task automatic t_err_op();
    int e0 = ev_cnt;
    send_field(16'b0111, 4, 1'b0);
    t_err("R6 opcode", 4, 3'd3);
    chk("R6 pulse count", ev_cnt, e0 + 1);
  endtask

  task automatic t_err_ta_w();
    int e0 = ev_cnt;
    send_field(16'b0101, 4, 1'b0);
    send_field(16'd0, 10, 1'b0);
    send_bit(1'b0, 1'b0);
    t_err("R7 write ta", 15, 3'd4);
    chk("R7 write ta count", ev_cnt, e0 + 1);
  endtask

  task automatic t_err_ta_r();
    int e0 = ev_cnt;
    send_field(16'b0110, 4, 1'b0);
    send_field(16'd0, 10, 1'b0);
    send_field(16'b11, 2, 1'b0);
    t_err("R7 read ta", 16, 3'd4);
    chk("R7 read ta count", ev_cnt, e0 + 1);
  endtask

  task automatic t_skip_masks();
    int f0 = fv_cnt;
    int e0 = ev_cnt;
    send_field(16'b00, 2, 1'b0);
    send_frame(1'b0, 2'b01, 5'h03, 5'h05, 2'b10, 16'h1234, 1'b0);
    send_ones(30);
    settle();
    chk("R8 masked frame", fv_cnt, f0);
    chk("R8 single error", ev_cnt, e0 + 1);
    send_frame(1'b0, 2'b10, 5'h07, 5'h09, 2'b10, 16'hBEEF, 1'b0);
    settle();
    check_frame("R8 after skip", f0, 1'b1, 5'h07, 5'h09, 16'hBEEF);
  endtask

  task automatic t_stall();
    int f0 = fv_cnt;
    int e0 = ev_cnt;
    send_field(16'b0111, 4, 1'b0);
    repeat (200) @(negedge clk);
    chk("R9 stall pulses", ev_cnt, e0 + 2);
    chk("R9 stall cause", last_cause, 3'd5);
    send_frame(1'b0, 2'b01, 5'h1E, 5'h02, 2'b10, 16'h5A5A, 1'b0);
    settle();
    check_frame("R9 idle after stall", f0, 1'b0, 5'h1E, 5'h02, 16'h5A5A);
    repeat (300) @(negedge clk);
    chk("R9 no stall outside skip", ev_cnt, e0 + 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write_pre();
    t_read_pre();
    t_no_pre();
    t_glitch();
    t_err_pre();
    t_err_sfd();
    t_err_op();
    t_err_ta_w();
    t_err_ta_r();
    t_write_pre();
    t_skip_masks();
    t_stall();
    chk("R10 pulse width and exclusion", wide_cnt, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule